// File: doc/BRIEF.md
# Soft-Processor Port-Bus Address Decoder

This block sits between the 8-bit port bus of a small soft processor and the devices that the processor reaches through that bus. On a write, the processor presents an address, a data byte and a one-cycle write strobe. The block decodes the address and steers the byte into one of three places: a 64-entry data RAM, a loop-back register, or a plain output register. Writes to any other address are dropped.

On the read side, the block returns a registered byte one clock after the address appears. The byte comes from the data RAM, a 64-entry constant table, the loop-back register, or a continuously sampled external input. Any address with no readable device returns zero. The processor does not care whether it formed the address from an immediate constant or from a register, because the block only sees the resulting address value.

A separate request latch drives the processor's interrupt line. An external pulse sets it, the processor's acknowledge pulse clears it, and the acknowledge wins if both arrive in the same cycle. Reset is synchronous and active high. It clears every register and the latch, but leaves the RAM contents alone.

Top module: `port_bus_decoder`

## Requirements
- R1: With the strobe high, a write to an address 0x00–0x3F stores the byte in RAM entry addr[5:0]. A later read of the same address returns that byte.
- R2: A read of an address 0x40–0x7F returns the constant-table entry for index i = addr[5:0]. That entry is (i*37 + 0x1B) mod 256 with the default parameters.
- R3: A write to an address 0x40–0x7F changes neither the constant table nor the RAM entry that has the same low six bits.
- R4: A write to 0x80 loads the loop-back register. Its value appears on `reg_a_out` one clock later, and a read of 0x80 returns it.
- R5: A write to 0xC0 loads `reg_b_out` one clock later. A read of 0xC0 returns 0x00, because nothing readable sits at that address.
- R6: Address 0xCF reads the external input through a sampling register, so a change on `ext_in` reaches `cpu_rdata` two clocks later. A write to 0xCF has no effect.
- R7: A read of an address with no readable device (0x81–0xBF, 0xC0–0xCE, 0xD0–0xFF) returns 0x00.
- R8: No storage changes on an edge where `cpu_wr` is low, whatever the address and data inputs are.
- R9: `cpu_rdata` shows the device addressed in the previous cycle. When that cycle also wrote the same location, the read returns the value held before the write.
- R10: A high `irq_req` sets `irq_out` on the next clock. A high `irq_ack` clears it and takes priority over `irq_req`. With both inputs low, `irq_out` holds its value.
- R11: An edge with `rst` high clears `reg_a_out`, `reg_b_out`, `irq_out` and `cpu_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 8 | Port address from the processor |
| cpu_wdata | input | 8 | Write data from the processor |
| cpu_wr | input | 1 | One-cycle write strobe |
| cpu_rdata | output | 8 | Registered read data, valid one clock after the address |
| ext_in | input | 8 | External byte, sampled every clock, read at 0xCF |
| reg_a_out | output | 8 | Loop-back register (address 0x80) |
| reg_b_out | output | 8 | Output register (address 0xC0) |
| irq_req | input | 1 | External interrupt set pulse |
| irq_ack | input | 1 | Processor acknowledge, clears the latch |
| irq_out | output | 1 | Interrupt line to the processor |

## Verification
The assertions check the following on every cycle:
- The interrupt latch obeys its set, clear and hold rules, with clear winning over set.
- The two output registers change only when a strobed write targets their own address.
- No write enable reaches any device while the strobe is low.
- An address with no readable device yields zero on the next cycle.
- Reset empties every register.

Three properties hold only across stored state, so only the bench's scenarios can show them:
- RAM and constant-table contents come back correctly on later reads.
- A strobed write to the table range leaves the aliased RAM entry intact.
- A read returns the old value when the same cycle also writes that location.

The two-clock path from the external input also depends on stored state and is checked by the bench.

// File: rtl/port_bus_pkg.sv
package port_bus_pkg;
  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_RAM,
    SRC_TABLE,
    SRC_LOOP,
    SRC_EXT
  } rd_src_e;
endpackage

// File: rtl/pb_addr_decode.sv
module pb_addr_decode
  import port_bus_pkg::*;
#(
  parameter int AW = 8,
  parameter int RAM_AW = 6,
  parameter logic [AW-1:0] LOOP_ADDR = 8'h80,
  parameter logic [AW-1:0] OUTB_ADDR = 8'hC0,
  parameter logic [AW-1:0] EXT_ADDR  = 8'hCF
) (
  input  logic [AW-1:0] addr,
  input  logic          wr,
  output logic          ram_we,
  output logic          loop_we,
  output logic          outb_we,
  output rd_src_e       rd_src
);
  localparam int RW = AW - RAM_AW;

  logic [RW-1:0] region;
  logic          in_ram, in_table;

  assign region   = addr[AW-1:RAM_AW];
  assign in_ram   = (region == RW'(0));
  assign in_table = (region == RW'(1));

  assign ram_we  = wr && in_ram;
  assign loop_we = wr && (addr == LOOP_ADDR);
  assign outb_we = wr && (addr == OUTB_ADDR);

  always_comb begin
    if (in_ram)                 rd_src = SRC_RAM;
    else if (in_table)          rd_src = SRC_TABLE;
    else if (addr == LOOP_ADDR) rd_src = SRC_LOOP;
    else if (addr == EXT_ADDR)  rd_src = SRC_EXT;
    else                        rd_src = SRC_NONE;
  end
endmodule

// File: rtl/pb_sync_ram.sv
module pb_sync_ram #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // read-before-write: rdata holds the entry as it was before this edge
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/pb_const_table.sv
module pb_const_table #(
  parameter int AW = 6,
  parameter int DW = 8,
  parameter int MUL = 37,
  parameter int ADD = 27
) (
  input  logic          clk,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rdata
);
  function automatic logic [DW-1:0] entry_of(input logic [AW-1:0] idx);
    logic [31:0] acc;
    acc = 32'(idx) * 32'(MUL) + 32'(ADD);
    return acc[DW-1:0];
  endfunction

  always_ff @(posedge clk) rdata <= entry_of(addr);
endmodule

// File: rtl/pb_irq_latch.sv
module pb_irq_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)        q <= 1'b0;
    else if (clr_i) q <= 1'b0;
    else if (set_i) q <= 1'b1;
  end

  AST_IRQ_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !q); // R10
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> q); // R10
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q)); // R10
endmodule

// File: rtl/port_bus_decoder.sv
module port_bus_decoder
  import port_bus_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int RAM_AW = 6,
  parameter logic [AW-1:0] LOOP_ADDR = 8'h80,
  parameter logic [AW-1:0] OUTB_ADDR = 8'hC0,
  parameter logic [AW-1:0] EXT_ADDR  = 8'hCF,
  parameter int TABLE_MUL = 37,
  parameter int TABLE_ADD = 27
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_wr,
  output logic [DW-1:0] cpu_rdata,
  input  logic [DW-1:0] ext_in,
  output logic [DW-1:0] reg_a_out,
  output logic [DW-1:0] reg_b_out,
  input  logic          irq_req,
  input  logic          irq_ack,
  output logic          irq_out
);
  logic          ram_we, loop_we, outb_we;
  rd_src_e       rd_src, sel_q;
  logic [DW-1:0] ram_q, table_q, ext_q, snap_q;

  pb_addr_decode #(
    .AW(AW), .RAM_AW(RAM_AW),
    .LOOP_ADDR(LOOP_ADDR), .OUTB_ADDR(OUTB_ADDR), .EXT_ADDR(EXT_ADDR)
  ) u_dec (
    .addr(cpu_addr), .wr(cpu_wr),
    .ram_we(ram_we), .loop_we(loop_we), .outb_we(outb_we), .rd_src(rd_src)
  );

  pb_sync_ram #(.AW(RAM_AW), .DW(DW)) u_ram (
    .clk(clk), .we(ram_we), .addr(cpu_addr[RAM_AW-1:0]),
    .wdata(cpu_wdata), .rdata(ram_q)
  );

  pb_const_table #(.AW(RAM_AW), .DW(DW), .MUL(TABLE_MUL), .ADD(TABLE_ADD)) u_tab (
    .clk(clk), .addr(cpu_addr[RAM_AW-1:0]), .rdata(table_q)
  );

  pb_irq_latch u_irq (
    .clk(clk), .rst(rst), .set_i(irq_req), .clr_i(irq_ack), .q(irq_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_a_out <= '0;
      reg_b_out <= '0;
      ext_q     <= '0;
      snap_q    <= '0;
      sel_q     <= SRC_NONE;
    end else begin
      if (loop_we) reg_a_out <= cpu_wdata;
      if (outb_we) reg_b_out <= cpu_wdata;
      ext_q <= ext_in;
      sel_q <= rd_src;
      case (rd_src)
        SRC_LOOP: snap_q <= reg_a_out;
        SRC_EXT:  snap_q <= ext_q;
        default:  snap_q <= '0;
      endcase
    end
  end

  always_comb begin
    case (sel_q)
      SRC_RAM:            cpu_rdata = ram_q;
      SRC_TABLE:          cpu_rdata = table_q;
      SRC_LOOP, SRC_EXT:  cpu_rdata = snap_q;
      default:            cpu_rdata = '0;
    endcase
  end

  AST_LOOP_LOAD: assert property (@(posedge clk) disable iff (rst)
    (cpu_wr && cpu_addr == LOOP_ADDR) |=> reg_a_out == $past(cpu_wdata)); // R4
  AST_LOOP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !loop_we |=> $stable(reg_a_out)); // R8
  AST_OUTB_HOLD: assert property (@(posedge clk) disable iff (rst)
    !outb_we |=> $stable(reg_b_out)); // R5
  AST_NO_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cpu_wr |-> !(ram_we || loop_we || outb_we)); // R8
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, loop_we, outb_we})); // R3
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_src == SRC_NONE) |=> cpu_rdata == '0); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (reg_a_out == '0 && reg_b_out == '0 && !irq_out && cpu_rdata == '0)); // R11
endmodule

// File: tb/port_bus_decoder_bench.sv
module port_bus_decoder_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cpu_addr = '0, cpu_wdata = '0, ext_in = '0;
  logic       cpu_wr = 1'b0, irq_req = 1'b0, irq_ack = 1'b0;
  logic [7:0] cpu_rdata, reg_a_out, reg_b_out;
  logic       irq_out;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  port_bus_decoder u_port_bus_decoder (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata), .ext_in(ext_in),
    .reg_a_out(reg_a_out), .reg_b_out(reg_b_out),
    .irq_req(irq_req), .irq_ack(irq_ack), .irq_out(irq_out)
  );

  typedef struct packed {
    logic       wr;
    logic       chk;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'h05, 8'hA7, 8'h00, 8'd1},  // R1 store
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'hA7, 8'd1},  // R1
    '{1'b1, 1'b0, 8'h3F, 8'h11, 8'h00, 8'd1},  // R1 top entry
    '{1'b0, 1'b1, 8'h3F, 8'h00, 8'h11, 8'd1},  // R1
    '{1'b1, 1'b0, 8'h00, 8'hE2, 8'h00, 8'd1},  // R1 bottom entry
    '{1'b0, 1'b1, 8'h00, 8'h00, 8'hE2, 8'd1},  // R1
    '{1'b0, 1'b1, 8'h40, 8'h00, 8'h1B, 8'd2},  // R2 index 0
    '{1'b0, 1'b1, 8'h7F, 8'h00, 8'h36, 8'd2},  // R2 index 63
    '{1'b1, 1'b1, 8'h45, 8'h99, 8'hD4, 8'd3},  // R3 write into table range
    '{1'b0, 1'b1, 8'h45, 8'h00, 8'hD4, 8'd3},  // R3 table unchanged
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'hA7, 8'd3},  // R3 aliased RAM unchanged
    '{1'b1, 1'b0, 8'h80, 8'h6D, 8'h00, 8'd4},  // R4 store
    '{1'b0, 1'b1, 8'h80, 8'h00, 8'h6D, 8'd4},  // R4 loop-back
    '{1'b1, 1'b1, 8'hC0, 8'h42, 8'h00, 8'd5},  // R5 write-only
    '{1'b0, 1'b1, 8'hC0, 8'h00, 8'h00, 8'd5},  // R5
    '{1'b0, 1'b1, 8'hCF, 8'h00, 8'h3C, 8'd6},  // R6
    '{1'b1, 1'b1, 8'hCF, 8'hFF, 8'h3C, 8'd6},  // R6 write ignored
    '{1'b0, 1'b1, 8'h81, 8'h00, 8'h00, 8'd7},  // R7
    '{1'b0, 1'b1, 8'hFF, 8'h00, 8'h00, 8'd7},  // R7
    '{1'b0, 1'b1, 8'hBF, 8'h00, 8'h00, 8'd7},  // R7
    '{1'b0, 1'b1, 8'h80, 8'h13, 8'h6D, 8'd8},  // R8 data without strobe
    '{1'b0, 1'b1, 8'h05, 8'h77, 8'hA7, 8'd8},  // R8
    '{1'b0, 1'b1, 8'h80, 8'h00, 8'h6D, 8'd8},  // R8
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'hA7, 8'd8},  // R8
    '{1'b1, 1'b1, 8'h05, 8'h58, 8'hA7, 8'd9},  // R9 read before write
    '{1'b0, 1'b1, 8'h05, 8'h00, 8'h58, 8'd9}   // R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    ext_in = 8'h3C;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", reg_a_out, 8'h00);
    check("R11", cpu_rdata, 8'h00);
    check("R11", {7'd0, irq_out}, 8'h00);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      cpu_wr    = VECS[i].wr;
      cpu_addr  = VECS[i].addr;
      cpu_wdata = VECS[i].wdata;
      @(negedge clk);
      if (VECS[i].chk) check($sformatf("R%0d vec %0d", VECS[i].req, i), cpu_rdata, VECS[i].exp);
    end
    cpu_wr = 1'b0;
    check("R4", reg_a_out, 8'h6D);
    check("R5", reg_b_out, 8'h42);
    // R6 two-clock latency from ext_in
    cpu_addr = 8'hCF;
    ext_in = 8'h81;
    @(negedge clk);
    check("R6", cpu_rdata, 8'h3C);
    @(negedge clk);
    check("R6", cpu_rdata, 8'h81);
    // R10 interrupt latch
    check("R10", {7'd0, irq_out}, 8'h00);
    irq_req = 1'b1;
    @(negedge clk);
    irq_req = 1'b0;
    check("R10", {7'd0, irq_out}, 8'h01);
    @(negedge clk);
    check("R10", {7'd0, irq_out}, 8'h01);
    irq_req = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    check("R10", {7'd0, irq_out}, 8'h00);
    irq_ack = 1'b0;
    @(negedge clk);
    check("R10", {7'd0, irq_out}, 8'h01);
    irq_req = 1'b0; irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    check("R10", {7'd0, irq_out}, 8'h00);
    // R11 reset in mid-run
    irq_req = 1'b1;
    cpu_addr = 8'h80;
    @(negedge clk);
    irq_req = 1'b0;
    check("R11", cpu_rdata, 8'h6D);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R11", reg_a_out, 8'h00);
    check("R11", reg_b_out, 8'h00);
    check("R11", cpu_rdata, 8'h00);
    check("R11", {7'd0, irq_out}, 8'h00);
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
    end
  end
endmodule